// File: doc/BRIEF.md
# Accumulator and Index Register 8-bit Processor Core

This core is a small 8-bit processor. Software sees only two data registers: an accumulator and one index register. Software also sees carry, negative and zero flags. No pointer register is visible to programs. Every memory operand address is taken from the two operand bytes that follow the opcode. Those bytes are captured in a hidden effective-address register, and the index is added for indexed forms. The address bus is narrowed to `AW` bits, which is 10 by default and gives 1024 bytes.

Each instruction is one opcode byte followed by zero, one or two operand bytes. When there are two operand bytes, the low byte comes first. The core makes one memory access per clock. Memory read data must be valid in the same cycle the address is driven. A write takes effect at the clock edge on which `mem_we` is high.

Timing per instruction:
- An implied instruction takes 1 cycle.
- An immediate or branch instruction takes 2 cycles.
- An absolute instruction takes 4 cycles: opcode, low base byte, high base byte, then the data access.

Reset is asynchronous and active low. The core starts fetching two clocks after reset is released.

Top module: `acc_index_core`

## Requirements
- R1: While reset is active, `mem_we` is 0 and `mem_addr` is 0. After reset, the first fetch is from address 0, and the accumulator, index and carry all read as 0.
- R2: These opcodes are defined: 0x01 LDX #imm, 0x02 LDA #imm, 0x03 CLC, 0x04 SEC, 0x05 DEX, 0x06 BPL rel, 0x07 BEQ rel, 0x08 ADC base,X, 0x09 LDA base,X, 0x0A STA base,X, 0x0B STA base, 0x0C STX base. Every other opcode byte, including 0x00, is a one-byte no-operation.
- R3: LDX #imm, LDA #imm and LDA base,X load the register. They set negative to bit 7 of the value and set zero when the value is 0.
- R4: ADC forms A + M + C. It writes the low 8 bits to A, bit 8 to carry, and updates negative and zero from the new A.
- R5: An indexed address is the 16-bit base plus the unsigned index, truncated to `AW` bits. For example, base 0x07F0 with X = 0x30 writes address 0x020.
- R6: STA base,X, STA base and STX base write one byte in a single cycle. They change no flag.
- R7: BPL branches when the negative flag is clear. The target is the address after the branch plus the sign-extended displacement byte.
- R8: BEQ branches under the same target rule when the zero flag is set.
- R9: DEX decrements the index modulo 256 and updates negative and zero.
- R10: CLC clears carry and SEC sets carry, and this carry feeds the next ADC.
- R11: A loop that counts X down from 15 with DEX and BPL runs its ADC body 16 times, including the pass with X = 0. It leaves X = 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | AW | Memory address for this cycle |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data for `mem_addr`, valid in the same cycle |
| mem_we | output | 1 | Write strobe |

## Verification
The bench builds the core with `AW` = 10 and attaches a full 1024-byte memory. A 16-bit base plus the index can therefore run past the top of the bus, which checks truncation. An index of 0xFF reaches past the end of a 256-byte window. With this size, the bench can sweep every index value through DEX and both branch conditions, and every load value through the zero and negative tests. It also covers a grid of addend pairs with both carry inputs through ADC.

// File: rtl/aic_pkg.sv
package aic_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {ST_FETCH, ST_OPLO, ST_OPHI, ST_MEM} st_e;

  typedef enum logic [3:0] {
    ACT_NOP, ACT_LDX, ACT_LDA, ACT_CLC, ACT_SEC, ACT_DEX,
    ACT_BPL, ACT_BEQ, ACT_ADC, ACT_LDM, ACT_STA, ACT_STX
  } act_e;

  typedef struct packed {
    act_e       act;
    logic [1:0] len;   // operand bytes after the opcode
    logic       idx;   // index added to the base
  } dec_t;

  localparam logic [DW-1:0] OPC_LDX_IMM = 8'h01;
  localparam logic [DW-1:0] OPC_LDA_IMM = 8'h02;
  localparam logic [DW-1:0] OPC_CLC     = 8'h03;
  localparam logic [DW-1:0] OPC_SEC     = 8'h04;
  localparam logic [DW-1:0] OPC_DEX     = 8'h05;
  localparam logic [DW-1:0] OPC_BPL     = 8'h06;
  localparam logic [DW-1:0] OPC_BEQ     = 8'h07;
  localparam logic [DW-1:0] OPC_ADC_IX  = 8'h08;
  localparam logic [DW-1:0] OPC_LDA_IX  = 8'h09;
  localparam logic [DW-1:0] OPC_STA_IX  = 8'h0A;
  localparam logic [DW-1:0] OPC_STA_AB  = 8'h0B;
  localparam logic [DW-1:0] OPC_STX_AB  = 8'h0C;
endpackage

// File: rtl/aic_decode.sv
module aic_decode
  import aic_pkg::*;
(
  input  logic [DW-1:0] opc,
  output dec_t          dec
);
  always_comb begin
    case (opc)
      OPC_LDX_IMM: dec = '{ACT_LDX, 2'd1, 1'b0};
      OPC_LDA_IMM: dec = '{ACT_LDA, 2'd1, 1'b0};
      OPC_CLC:     dec = '{ACT_CLC, 2'd0, 1'b0};
      OPC_SEC:     dec = '{ACT_SEC, 2'd0, 1'b0};
      OPC_DEX:     dec = '{ACT_DEX, 2'd0, 1'b0};
      OPC_BPL:     dec = '{ACT_BPL, 2'd1, 1'b0};
      OPC_BEQ:     dec = '{ACT_BEQ, 2'd1, 1'b0};
      OPC_ADC_IX:  dec = '{ACT_ADC, 2'd2, 1'b1};
      OPC_LDA_IX:  dec = '{ACT_LDM, 2'd2, 1'b1};
      OPC_STA_IX:  dec = '{ACT_STA, 2'd2, 1'b1};
      OPC_STA_AB:  dec = '{ACT_STA, 2'd2, 1'b0};
      OPC_STX_AB:  dec = '{ACT_STX, 2'd2, 1'b0};
      default:     dec = '{ACT_NOP, 2'd0, 1'b0};
    endcase
  end
endmodule

// File: rtl/aic_alu.sv
module aic_alu
  import aic_pkg::*;
(
  input  logic          en,
  input  act_e          act,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] x,
  input  logic          c,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] a_d,
  output logic [DW-1:0] x_d,
  output logic          c_d,
  output logic          n_d,
  output logic          z_d,
  output logic          ld_a,
  output logic          ld_x,
  output logic          ld_c,
  output logic          ld_nz
);
  logic [DW:0]   sum;
  logic [DW-1:0] res;

  always_comb begin
    a_d   = a;
    x_d   = x;
    c_d   = c;
    res   = '0;
    ld_a  = 1'b0;
    ld_x  = 1'b0;
    ld_c  = 1'b0;
    ld_nz = 1'b0;
    sum   = {1'b0, a} + {1'b0, opnd} + {{DW{1'b0}}, c};
    if (en) begin
      case (act)
        ACT_LDX: begin x_d = opnd; res = opnd; ld_x = 1'b1; ld_nz = 1'b1; end
        ACT_LDA, ACT_LDM: begin
          a_d = opnd; res = opnd; ld_a = 1'b1; ld_nz = 1'b1;
        end
        ACT_CLC: begin c_d = 1'b0; ld_c = 1'b1; end
        ACT_SEC: begin c_d = 1'b1; ld_c = 1'b1; end
        ACT_DEX: begin
          x_d = x - {{(DW-1){1'b0}}, 1'b1}; res = x_d; ld_x = 1'b1; ld_nz = 1'b1;
        end
        ACT_ADC: begin
          a_d = sum[DW-1:0]; c_d = sum[DW]; res = sum[DW-1:0];
          ld_a = 1'b1; ld_c = 1'b1; ld_nz = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign n_d = res[DW-1];
  assign z_d = (res == '0);
endmodule

// File: rtl/aic_agen.sv
module aic_agen
  import aic_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] x,
  input  logic          idx,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] br_tgt
);
  localparam int BW  = 2 * DW;
  localparam int PAD = AW - DW;

  generate
    if (AW <= DW || AW > BW) begin : g_bad_aw
      $error("AW must lie between DW+1 and 2*DW");
    end
  endgenerate

  logic [BW-1:0] base;
  logic [DW-1:0] off;

  assign base   = {opnd, lo};
  assign off    = idx ? x : '0;
  assign ea     = AW'(base + {{DW{1'b0}}, off});
  assign br_tgt = pc + AW'(1) + {{PAD{opnd[DW-1]}}, opnd};
endmodule

// File: rtl/acc_index_core.sv
module acc_index_core
  import aic_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we
);
  localparam logic [AW-1:0] PC_ONE = AW'(1);

  logic          sync_q, run_q;
  st_e           st_q, st_d;
  logic [AW-1:0] pc_q, pc_d;
  dec_t          ir_q, ir_d, dec_w, cur;
  logic [DW-1:0] lo_q, lo_d;
  logic [AW-1:0] ea_q, ea_d, ea_w, br_tgt;
  logic [DW-1:0] a_q, x_q, a_d, x_d;
  logic          c_q, n_q, z_q, c_d, n_d, z_d;
  logic          ld_a, ld_x, ld_c, ld_nz;
  logic          exe, taken;

  aic_decode u_dec (.opc(mem_rdata), .dec(dec_w));

  aic_alu u_alu (
    .en(exe), .act(cur.act), .a(a_q), .x(x_q), .c(c_q), .opnd(mem_rdata),
    .a_d(a_d), .x_d(x_d), .c_d(c_d), .n_d(n_d), .z_d(z_d),
    .ld_a(ld_a), .ld_x(ld_x), .ld_c(ld_c), .ld_nz(ld_nz)
  );

  aic_agen #(.AW(AW)) u_agen (
    .pc(pc_q), .opnd(mem_rdata), .lo(lo_q), .x(x_q), .idx(ir_q.idx),
    .ea(ea_w), .br_tgt(br_tgt)
  );

  assign taken = (ir_q.act == ACT_BPL && !n_q) || (ir_q.act == ACT_BEQ && z_q);

  // next state
  always_comb begin
    st_d      = st_q;
    pc_d      = pc_q;
    ir_d      = ir_q;
    lo_d      = lo_q;
    ea_d      = ea_q;
    cur       = ir_q;
    mem_addr  = pc_q;
    mem_wdata = a_q;
    mem_we    = 1'b0;
    exe       = 1'b0;
    case (st_q)
      ST_FETCH: begin
        cur  = dec_w;
        ir_d = dec_w;
        pc_d = pc_q + PC_ONE;
        if (dec_w.len == 2'd0) exe = 1'b1;
        else                   st_d = ST_OPLO;
      end
      ST_OPLO: begin
        pc_d = pc_q + PC_ONE;
        if (ir_q.len == 2'd1) begin
          exe  = 1'b1;
          st_d = ST_FETCH;
          if (taken) pc_d = br_tgt;
        end else begin
          lo_d = mem_rdata;
          st_d = ST_OPHI;
        end
      end
      ST_OPHI: begin
        pc_d = pc_q + PC_ONE;
        ea_d = ea_w;
        st_d = ST_MEM;
      end
      ST_MEM: begin
        mem_addr = ea_q;
        st_d     = ST_FETCH;
        if (ir_q.act == ACT_STA) begin
          mem_we = 1'b1;
        end else if (ir_q.act == ACT_STX) begin
          mem_we    = 1'b1;
          mem_wdata = x_q;
        end else begin
          exe = 1'b1;
        end
      end
    endcase
  end

  // reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      sync_q <= 1'b1;
      run_q  <= sync_q;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FETCH;
      pc_q <= '0;
      ir_q <= '0;
      lo_q <= '0;
      ea_q <= '0;
      a_q  <= '0;
      x_q  <= '0;
      c_q  <= 1'b0;
      n_q  <= 1'b0;
      z_q  <= 1'b0;
    end else if (run_q) begin
      st_q <= st_d;
      pc_q <= pc_d;
      ir_q <= ir_d;
      lo_q <= lo_d;
      ea_q <= ea_d;
      if (ld_a) a_q <= a_d;
      if (ld_x) x_q <= x_d;
      if (ld_c) c_q <= c_d;
      if (ld_nz) begin
        n_q <= n_d;
        z_q <= z_d;
      end
    end
  end
endmodule

// File: rtl/aic_core_chk.sv
module aic_core_chk
  import aic_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_q,
  input logic          exe,
  input act_e          act,
  input st_e           st_q,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] x_q,
  input logic          c_q,
  input logic          n_q,
  input logic          z_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!mem_we && mem_addr == '0));

  // R1
  first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (st_q == ST_FETCH && mem_addr == '0 && !mem_we));

  // R6
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R9
  dex_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && exe && act == ACT_DEX) |=>
      (x_q == $past(x_q) - 8'd1 && n_q == x_q[DW-1] && z_q == (x_q == '0)));

  // R4
  adc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && exe && act == ACT_ADC) |=>
      ({c_q, a_q} == {1'b0, $past(a_q)} + {1'b0, $past(mem_rdata)} + {8'd0, $past(c_q)}));

  // R3
  ldx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && exe && act == ACT_LDX) |=>
      (x_q == $past(mem_rdata) && n_q == x_q[DW-1] && z_q == (x_q == '0)));
endmodule

bind acc_index_core aic_core_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .exe(exe), .act(cur.act),
  .st_q(st_q), .mem_addr(mem_addr), .mem_we(mem_we), .mem_rdata(mem_rdata),
  .a_q(a_q), .x_q(x_q), .c_q(c_q), .n_q(n_q), .z_q(z_q)
);

// File: tb/acc_index_core_tb.sv
module acc_index_core_tb_top;
  localparam int AW   = 10;
  localparam int MEMD = 1 << AW;

  logic          clk, rst_n;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          mem_we;
  logic          ld_en;
  logic [AW-1:0] ld_addr;
  logic [7:0]    ld_data;
  logic [7:0]    mem [0:MEMD-1];
  int            n_tot, n_bad, pl;
  logic          done;

  acc_index_core #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr]  <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic ld(input int a, input logic [7:0] d);
    ld_en   = 1'b1;
    ld_addr = AW'(a);
    ld_data = d;
    @(posedge clk);
    #1;
    ld_en = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    ld(pl, d);
    pl++;
  endtask

  task automatic start();
    rst_n = 1'b0;
    pl    = 0;
  endtask

  task automatic go(input int n);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tot++;
      n_bad++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    n_tot = 0; n_bad = 0; done = 1'b0; pl = 0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    for (int i = 0; i < MEMD; i++) ld(i, 8'h00);

    // R4 R10: addend grid, both carry inputs
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [7:0] av, bv;
          int s;
          av = 8'(ai * 17);
          bv = 8'(bi * 17 + ci * 3);
          start();
          put(8'h02); put(av);
          put(ci == 1 ? 8'h04 : 8'h03);
          put(8'h01); put(8'h00);
          put(8'h08); put(8'h00); put(8'h02);
          put(8'h0A); put(8'h10); put(8'h02);
          put(8'h02); put(8'h00);
          put(8'h08); put(8'h01); put(8'h02);
          put(8'h0A); put(8'h11); put(8'h02);
          put(8'h06); put(8'hFE);
          ld(16'h200, bv); ld(16'h201, 8'h00);
          go(34);
          s = int'(av) + int'(bv) + ci;
          chk("R4 adc sum", {8'h00, mem[16'h210]}, 16'(s & 255));
          chk("R10 carry in/out", {8'h00, mem[16'h211]}, 16'(s >> 8));
        end
      end
    end

    // R1: bus quiet during reset, registers cleared after it
    start();
    ld(16'h350, 8'hEE); ld(16'h351, 8'hEE); ld(16'h352, 8'h00); ld(16'h353, 8'hEE);
    chk("R1 addr in reset", 16'(mem_addr), 16'h0);
    chk("R1 we in reset", {15'd0, mem_we}, 16'h0);
    put(8'h0A); put(8'h50); put(8'h03);
    put(8'h0C); put(8'h51); put(8'h03);
    put(8'h08); put(8'h52); put(8'h03);
    put(8'h0B); put(8'h53); put(8'h03);
    put(8'h06); put(8'hFE);
    go(30);
    chk("R1 A cleared", {8'h00, mem[16'h350]}, 16'h0);
    chk("R1 X cleared", {8'h00, mem[16'h351]}, 16'h0);
    chk("R1 carry cleared", {8'h00, mem[16'h353]}, 16'h0);

    // R9 R7 R6: every index value through DEX, then BPL
    for (int xv = 0; xv < 256; xv++) begin
      logic [7:0] xe;
      start();
      put(8'h01); put(8'(xv));
      put(8'h05);
      put(8'h0C); put(8'h00); put(8'h03);
      put(8'h06); put(8'h07);
      put(8'h02); put(8'h11);
      put(8'h0B); put(8'h01); put(8'h03);
      put(8'h06); put(8'hFE);
      put(8'h02); put(8'h22);
      put(8'h0B); put(8'h01); put(8'h03);
      put(8'h06); put(8'hFE);
      go(32);
      xe = 8'(xv - 1);
      chk("R9 dex value", {8'h00, mem[16'h300]}, {8'h00, xe});
      chk("R7 bpl on negative", {8'h00, mem[16'h301]}, xe[7] ? 16'h11 : 16'h22);
    end

    // R3 R8 R7 R6: every load value, both branch kinds, store keeps flags
    for (int vv = 0; vv < 256; vv++) begin
      for (int br = 0; br < 2; br++) begin
        logic [7:0] v;
        logic tk;
        logic imm;
        v   = 8'(vv);
        imm = (br == 1) ? ~v[0] : v[0];
        start();
        put(8'h01); put(8'h00);
        if (imm) begin put(8'h02); put(v); put(8'h00); end
        else     begin put(8'h09); put(8'h00); put(8'h02); end
        put(8'h0A); put(8'h02); put(8'h03);
        put(br == 1 ? 8'h06 : 8'h07); put(8'h07);
        put(8'h02); put(8'h11);
        put(8'h0B); put(8'h01); put(8'h03);
        put(8'h06); put(8'hFE);
        put(8'h02); put(8'h22);
        put(8'h0B); put(8'h01); put(8'h03);
        put(8'h06); put(8'hFE);
        ld(16'h200, v);
        go(36);
        tk = (br == 1) ? ~v[7] : (v == 8'h00);
        chk("R3 load value", {8'h00, mem[16'h302]}, {8'h00, v});
        if (br == 1) chk("R3 R7 negative flag branch", {8'h00, mem[16'h301]}, tk ? 16'h22 : 16'h11);
        else         chk("R3 R8 zero flag branch", {8'h00, mem[16'h301]}, tk ? 16'h22 : 16'h11);
      end
    end

    // R5: indexed address past the bus top wraps
    start();
    ld(16'h020, 8'h00); ld(16'h220, 8'h00);
    put(8'h02); put(8'h5A);
    put(8'h01); put(8'h30);
    put(8'h0A); put(8'hF0); put(8'h07);
    put(8'h06); put(8'hFE);
    go(20);
    chk("R5 wrapped store", {8'h00, mem[16'h020]}, 16'h5A);
    chk("R5 no alias store", {8'h00, mem[16'h220]}, 16'h00);

    // R2: undefined opcodes are single bytes
    start();
    ld(16'h340, 8'h00);
    put(8'hFF); put(8'h3C); put(8'h00);
    put(8'h02); put(8'h77);
    put(8'h0B); put(8'h40); put(8'h03);
    put(8'h06); put(8'hFE);
    go(20);
    chk("R2 nop length", {8'h00, mem[16'h340]}, 16'h77);

    // R11 R5: summing loop, several data patterns
    for (int p = 0; p < 4; p++) begin
      logic [7:0] acc;
      logic cy;
      int s;
      start();
      put(8'h01); put(8'h0F);
      put(8'h02); put(8'h00);
      put(8'h03);
      put(8'h08); put(8'h00); put(8'h01);
      put(8'h05);
      put(8'h06); put(8'hFA);
      put(8'h0A); put(8'h20); put(8'h01);
      put(8'h01); put(8'h00);
      put(8'h06); put(8'hFE);
      for (int i = 0; i < 16; i++) ld(16'h100 + i, 8'((i * (p * 37 + 5) + p * 60) & 255));
      ld(16'h120, 8'hA5); ld(16'h21F, 8'h00);
      acc = 8'h00;
      cy  = 1'b0;
      for (int i = 15; i >= 0; i--) begin
        s   = int'(acc) + ((i * (p * 37 + 5) + p * 60) & 255) + int'(cy);
        acc = 8'(s);
        cy  = (s > 255);
      end
      go(160);
      chk("R11 loop sum at X=FF", {8'h00, mem[16'h21F]}, {8'h00, acc});
      chk("R11 base untouched", {8'h00, mem[16'h120]}, 16'hA5);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule